// File: doc/BRIEF.md
# Descriptor Ring Retirement Tracker

This block follows the consumer side of a transmit descriptor ring. Hardware reports how far it has read the ring (its head index). Software keeps a FIFO of outstanding packet requests. Each request carries a start index, an end index (one past its last descriptor), a flag that asks for each descriptor to be released, and a tag. When a retirement pass is kicked while the engine runs, the tracker walks its own head towards the hardware head at one descriptor per cycle. For each descriptor that belongs to the oldest request and has its release flag set, it emits a release pulse. It emits an OK completion when the head passes that request's end index.

There are two ways to flush the FIFO. The first is an abort request. It releases the remaining descriptors of every release-flagged request and completes all requests as aborted, oldest first. It then resets the ring pointers and resynchronises the removed counter to the added counter. The second is a submission made while the engine is stopped. Such a request is queued with no descriptors and completed as aborted, in order behind the requests already waiting. This flush leaves the counters untouched. The tracker also keeps the producer tail, the 2-bit wrap generation, the added and removed counts, and the free-slot count.

Top module: `dret_tracker`

## Requirements
- R1: During a pass, each cycle in which the local head differs from the hardware head, the head advances by one, wrapping from RING_DEPTH-1 to 0, and removed_cnt increments. The pass ends when the head equals the hardware head.
- R2: A retired descriptor gets a release pulse (rel_idx = head) only if the oldest request has its release flag set and its running index equals the head. The running index starts at the request's start index and advances with wrap on every release.
- R3: When the head steps onto the oldest request's end index, that request is popped and done_valid pulses with its tag and done_status = 0 (OK). Tracking then moves to the next request's start index. A release and a completion may occur in the same cycle.
- R4: Descriptors not covered by any pending request are retired (head and removed_cnt advance) with no release and no completion.
- R5: A pass starts only on retire_kick while eng_running is 1. A kick while stopped leaves the head unchanged. A pass in progress stops when eng_running drops.
- R6: abort_req flushes the FIFO oldest first. For each release-flagged request it first pulses the remaining descriptors from its running index up to its end index. Each request then completes with done_status = 1 (aborted).
- R7: After an abort flush, head, tail and generation are 0 and removed_cnt equals the added count (free_cnt = RING_DEPTH-1). removed_cnt never decreases, modulo its width.
- R8: A submission while eng_running is 0 is queued as a zero-descriptor request with its release flag cleared. It completes as aborted behind all earlier requests, whose remaining releases and aborted completions come first. Tail, generation and counters are unchanged.
- R9: When a pass that retired at least one descriptor ends, progress pulses once. free_cnt = RING_DEPTH-1-(added-removed) is always available.
- R10: An accepted submission while running sets tail to its end index and adds sub_ndesc to the added count. Generation increments when the new end index is below the previous tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_running | input | 1 | Engine is in its running state |
| hw_head | input | IDX_W | Head index reported by hardware |
| retire_kick | input | 1 | Start a retirement pass (interrupt) |
| abort_req | input | 1 | Flush all requests as aborted and resync |
| sub_valid | input | 1 | Submit a request this cycle |
| sub_start | input | IDX_W | First descriptor index of the request |
| sub_end | input | IDX_W | One past the last descriptor index |
| sub_ndesc | input | IDX_W | Descriptors written since the previous tail |
| sub_release | input | 1 | Release each descriptor on retirement |
| sub_tag | input | TAG_W | Request identifier returned on completion |
| rel_valid | output | 1 | Release pulse |
| rel_idx | output | IDX_W | Index of the released descriptor |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completed request |
| done_status | output | 1 | 0 OK, 1 aborted |
| progress | output | 1 | Pass ended having retired descriptors |
| free_cnt | output | CNT_W | Free ring slots |
| head_idx | output | IDX_W | Local head |
| tail_idx | output | IDX_W | Local tail |
| generation | output | 2 | Tail wrap generation |
| removed_cnt | output | CNT_W | Retired descriptor count |

## Verification
The release of a request's last descriptor and that request's OK completion fall in the same cycle. The bench provokes this with a release-flagged request followed directly by another request. Its scoreboard expects the release before the completion and checks both pulses in one sampling. During flushes, several releases in a row must come before the aborted completion of the same request. The order of the queued items covers this case too.

// File: rtl/dret_pkg.sv
// Shared types for the descriptor retirement tracker.
// Assumes nothing beyond being compiled before its users.
package dret_pkg;
    typedef enum logic [1:0] {
        M_IDLE   = 2'd0,
        M_RETIRE = 2'd1,
        M_FLUSH  = 2'd2
    } trk_mode_e;

    localparam logic ST_OK    = 1'b0;
    localparam logic ST_ABORT = 1'b1;
endpackage

// File: rtl/trk_req_fifo.sv
// Request FIFO: holds pending packet requests, exposes the oldest entry.
// Assumes the user never pushes when full nor pops when empty; a push and
// a pop in the same cycle are both honoured.
module trk_req_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] front,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_q, rd_q;
    logic [AW:0]  count;

    assign count = wr_q - rd_q;
    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign front = mem[rd_q[AW-1:0]];

    // Pointer update on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push && !full) wr_q <= wr_q + 1'b1;
            if (pop && !empty) rd_q <= rd_q + 1'b1;
        end
    end

    // Storage write, one slot per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && wr_q[AW-1:0] == AW'(g)) mem[g] <= din;
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH)); // R8
endmodule

// File: rtl/trk_ring_state.sv
// Ring pointer and counter state: local head, producer tail, wrap generation,
// added and removed descriptor counts, and the derived free-slot count.
// Assumes step and resync are never asserted together.
module trk_ring_state #(
    parameter int RING_DEPTH = 16,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             resync,
    input  logic             ring_push,
    input  logic [IDX_W-1:0] push_end,
    input  logic [IDX_W-1:0] push_ndesc,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [1:0]       gen,
    output logic [CNT_W-1:0] removed,
    output logic [CNT_W-1:0] free_cnt
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);
    localparam logic [CNT_W-1:0] CAPACITY = CNT_W'(RING_DEPTH - 1);

    logic [CNT_W-1:0] added;

    assign free_cnt = CAPACITY - (added - removed);

    // Consumer side: head and removed count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            removed <= '0;
        end else if (resync) begin
            head    <= '0;
            removed <= added;
        end else if (step) begin
            head    <= (head == LAST_IDX) ? '0 : head + 1'b1;
            removed <= removed + 1'b1;
        end
    end

    // Producer side: tail, generation and added count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail  <= '0;
            gen   <= '0;
            added <= '0;
        end else if (resync) begin
            tail <= '0;
            gen  <= '0;
        end else if (ring_push) begin
            tail  <= push_end;
            added <= added + CNT_W'(push_ndesc);
            if (push_end < tail) gen <= gen + 1'b1;
        end
    end

    AST_REMOVED_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (removed - $past(removed)) < (CNT_W'(1) << (CNT_W - 1))); // R7
    AST_HEAD_MOVES_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head) |-> (head == '0) || (head == $past(head) + 1'b1)); // R1
endmodule

// File: rtl/trk_sequencer.sv
// Sequencer: idle / retire-pass / flush control. Walks the head towards the
// hardware head, matches retired descriptors against the oldest request,
// and drains the FIFO on abort or stopped-engine submission. All pulses are
// registered, so they appear one cycle after the deciding step.
// Assumes submissions are not made during a flush and that a running
// submission has at least one descriptor.
module trk_sequencer
    import dret_pkg::*;
#(
    parameter int RING_DEPTH = 16,
    parameter int TAG_W      = 4,
    localparam int IDX_W     = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_running,
    input  logic [IDX_W-1:0] hw_head,
    input  logic             kick,
    input  logic             abort_req,
    input  logic             sub_valid,
    input  logic [IDX_W-1:0] sub_start,
    input  logic [IDX_W-1:0] sub_end,
    input  logic             sub_rel,
    input  logic [TAG_W-1:0] sub_tag,
    input  logic [IDX_W-1:0] head,
    input  logic             fifo_empty,
    input  logic             fifo_full,
    input  logic [IDX_W-1:0] fr_start,
    input  logic [IDX_W-1:0] fr_end,
    input  logic             fr_rel,
    input  logic [TAG_W-1:0] fr_tag,
    output logic             push,
    output logic [IDX_W-1:0] push_start,
    output logic [IDX_W-1:0] push_end,
    output logic             push_rel,
    output logic [TAG_W-1:0] push_tag,
    output logic             pop,
    output logic             ring_push,
    output logic             step,
    output logic             resync,
    output logic             rel_q,
    output logic [IDX_W-1:0] rel_idx_q,
    output logic             done_q,
    output logic [TAG_W-1:0] done_tag_q,
    output logic             done_st_q,
    output logic             prog_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] x);
        return (x == LAST_IDX) ? '0 : x + 1'b1;
    endfunction

    trk_mode_e        mode_q, mode_d;
    logic [IDX_W-1:0] run_q, run_d, cur_run, head_n;
    logic             run_ld_q, run_ld_d;
    logic             rstp_q, rstp_d;
    logic             any_q, any_d;
    logic             rel_d, done_d, done_st_d, prog_d;
    logic [IDX_W-1:0] rel_idx_d;
    logic [TAG_W-1:0] done_tag_d;
    logic             sub_ok, sub_stopped;

    assign cur_run     = run_ld_q ? run_q : fr_start;
    assign head_n      = nxt(head);
    assign sub_ok      = (mode_q != M_FLUSH) && sub_valid && !fifo_full;
    assign sub_stopped = sub_ok && !eng_running;

    // Next-state and pulse decisions for the three modes.
    always_comb begin
        mode_d     = mode_q;
        run_d      = run_q;
        run_ld_d   = run_ld_q;
        rstp_d     = rstp_q;
        any_d      = any_q;
        push       = sub_ok;
        push_start = eng_running ? sub_start : '0;
        push_end   = eng_running ? sub_end   : '0;
        push_rel   = eng_running ? sub_rel   : 1'b0;
        push_tag   = sub_tag;
        ring_push  = sub_ok && eng_running;
        pop        = 1'b0;
        step       = 1'b0;
        resync     = 1'b0;
        rel_d      = 1'b0;
        rel_idx_d  = head;
        done_d     = 1'b0;
        done_tag_d = fr_tag;
        done_st_d  = ST_OK;
        prog_d     = 1'b0;
        unique case (mode_q)
            M_IDLE, M_RETIRE: begin
                if (abort_req) begin
                    mode_d = M_FLUSH;
                    rstp_d = 1'b1;
                end else if (sub_stopped) begin
                    mode_d = M_FLUSH;
                end else if (mode_q == M_IDLE) begin
                    if (kick && eng_running) begin
                        mode_d = M_RETIRE;
                        any_d  = 1'b0;
                    end
                end else if (!eng_running) begin
                    mode_d = M_IDLE;
                end else if (head == hw_head) begin
                    mode_d = M_IDLE;
                    prog_d = any_q;
                end else begin
                    step  = 1'b1;
                    any_d = 1'b1;
                    if (!fifo_empty && fr_rel && cur_run == head) begin
                        rel_d     = 1'b1;
                        rel_idx_d = head;
                        run_d     = nxt(cur_run);
                        run_ld_d  = 1'b1;
                    end
                    if (!fifo_empty && fr_end == head_n) begin
                        pop      = 1'b1;
                        done_d   = 1'b1;
                        run_ld_d = 1'b0;
                    end
                end
            end
            M_FLUSH: begin
                if (fifo_empty) begin
                    resync   = rstp_q;
                    rstp_d   = 1'b0;
                    run_ld_d = 1'b0;
                    mode_d   = M_IDLE;
                end else if (fr_rel && cur_run != fr_end) begin
                    rel_d     = 1'b1;
                    rel_idx_d = cur_run;
                    run_d     = nxt(cur_run);
                    run_ld_d  = 1'b1;
                end else begin
                    pop       = 1'b1;
                    done_d    = 1'b1;
                    done_st_d = ST_ABORT;
                    run_ld_d  = 1'b0;
                end
            end
            default: mode_d = M_IDLE;
        endcase
    end

    // Mode, running index and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= M_IDLE;
            run_q    <= '0;
            run_ld_q <= 1'b0;
            rstp_q   <= 1'b0;
            any_q    <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            run_q    <= run_d;
            run_ld_q <= run_ld_d;
            rstp_q   <= rstp_d;
            any_q    <= any_d;
        end
    end

    // Registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q      <= 1'b0;
            rel_idx_q  <= '0;
            done_q     <= 1'b0;
            done_tag_q <= '0;
            done_st_q  <= ST_OK;
            prog_q     <= 1'b0;
        end else begin
            rel_q      <= rel_d;
            rel_idx_q  <= rel_idx_d;
            done_q     <= done_d;
            done_tag_q <= done_tag_d;
            done_st_q  <= done_st_d;
            prog_q     <= prog_d;
        end
    end

    AST_REL_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |-> $past(!fifo_empty)); // R2
    AST_STOPPED_NO_OK: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_running |=> (!done_q || done_st_q == ST_ABORT)); // R5
    AST_FLUSH_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_FLUSH) |=> (!done_q || done_st_q == ST_ABORT)); // R6
    AST_PROGRESS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_q |-> $past(!step)); // R9
endmodule

// File: rtl/dret_tracker.sv
// Top of the descriptor retirement tracker: wires the request FIFO, the
// ring pointer/counter state and the sequencer together.
// Assumes hw_head only moves within the span software has submitted.
module dret_tracker #(
    parameter int RING_DEPTH = 16,
    parameter int REQ_DEPTH  = 8,
    parameter int TAG_W      = 4,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_running,
    input  logic [IDX_W-1:0] hw_head,
    input  logic             retire_kick,
    input  logic             abort_req,
    input  logic             sub_valid,
    input  logic [IDX_W-1:0] sub_start,
    input  logic [IDX_W-1:0] sub_end,
    input  logic [IDX_W-1:0] sub_ndesc,
    input  logic             sub_release,
    input  logic [TAG_W-1:0] sub_tag,
    output logic             rel_valid,
    output logic [IDX_W-1:0] rel_idx,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag,
    output logic             done_status,
    output logic             progress,
    output logic [CNT_W-1:0] free_cnt,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [1:0]       generation,
    output logic [CNT_W-1:0] removed_cnt
);
    localparam int ENT_W = 2 * IDX_W + 1 + TAG_W;

    logic             push, pop, ring_push, step, resync;
    logic             fifo_empty, fifo_full;
    logic [IDX_W-1:0] push_start, push_end, fr_start, fr_end;
    logic             push_rel, fr_rel;
    logic [TAG_W-1:0] push_tag, fr_tag;
    logic [ENT_W-1:0] fifo_din, fifo_front;

    assign fifo_din = {push_start, push_end, push_rel, push_tag};
    assign {fr_start, fr_end, fr_rel, fr_tag} = fifo_front;

    trk_req_fifo #(.DEPTH(REQ_DEPTH), .W(ENT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(fifo_din), .pop(pop),
        .front(fifo_front), .empty(fifo_empty), .full(fifo_full)
    );

    trk_ring_state #(.RING_DEPTH(RING_DEPTH), .CNT_W(CNT_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .step(step), .resync(resync),
        .ring_push(ring_push), .push_end(sub_end), .push_ndesc(sub_ndesc),
        .head(head_idx), .tail(tail_idx), .gen(generation),
        .removed(removed_cnt), .free_cnt(free_cnt)
    );

    trk_sequencer #(.RING_DEPTH(RING_DEPTH), .TAG_W(TAG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .eng_running(eng_running), .hw_head(hw_head),
        .kick(retire_kick), .abort_req(abort_req), .sub_valid(sub_valid),
        .sub_start(sub_start), .sub_end(sub_end), .sub_rel(sub_release),
        .sub_tag(sub_tag), .head(head_idx), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fr_start(fr_start), .fr_end(fr_end),
        .fr_rel(fr_rel), .fr_tag(fr_tag), .push(push), .push_start(push_start),
        .push_end(push_end), .push_rel(push_rel), .push_tag(push_tag),
        .pop(pop), .ring_push(ring_push), .step(step), .resync(resync),
        .rel_q(rel_valid), .rel_idx_q(rel_idx), .done_q(done_valid),
        .done_tag_q(done_tag), .done_st_q(done_status), .prog_q(progress)
    );
endmodule

// File: tb/dret_tracker_test.sv
// Scoreboard bench: driver tasks queue expected release/completion events,
// a monitor at the falling edge pops and compares them.
module dret_tracker_test;
    localparam int RD = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          eng_running = 1'b0;
    logic [IW-1:0] hw_head = '0;
    logic          retire_kick = 1'b0, abort_req = 1'b0, sub_valid = 1'b0;
    logic [IW-1:0] sub_start = '0, sub_end = '0, sub_ndesc = '0;
    logic          sub_release = 1'b0;
    logic [3:0]    sub_tag = '0;
    logic          rel_valid, done_valid, done_status, progress;
    logic [IW-1:0] rel_idx, head_idx, tail_idx;
    logic [3:0]    done_tag;
    logic [15:0]   free_cnt, removed_cnt;
    logic [1:0]    generation;

    dret_tracker uut (
        .clk(clk), .rst_n(rst_n), .eng_running(eng_running), .hw_head(hw_head),
        .retire_kick(retire_kick), .abort_req(abort_req), .sub_valid(sub_valid),
        .sub_start(sub_start), .sub_end(sub_end), .sub_ndesc(sub_ndesc),
        .sub_release(sub_release), .sub_tag(sub_tag), .rel_valid(rel_valid),
        .rel_idx(rel_idx), .done_valid(done_valid), .done_tag(done_tag),
        .done_status(done_status), .progress(progress), .free_cnt(free_cnt),
        .head_idx(head_idx), .tail_idx(tail_idx), .generation(generation),
        .removed_cnt(removed_cnt)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    int exp_q[$];
    string exp_r[$];
    int prog_seen = 0;
    int prog_free = -1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic exp_rel(input int idx, input string req);
        exp_q.push_back(32'h1000 | idx);
        exp_r.push_back(req);
    endtask

    task automatic exp_done(input int tag, input int st, input string req);
        exp_q.push_back(32'h2000 | (st << 8) | tag);
        exp_r.push_back(req);
    endtask

    task automatic compare(input int got);
        if (exp_q.size() == 0) chk(1'b0, "unexpected-event", got, 0);
        else begin
            int e = exp_q.pop_front();
            string r = exp_r.pop_front();
            chk(got == e, r, got, e);
        end
    endtask

    // Monitor: compares produced events with queued expectations.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rel_valid)  compare(32'h1000 | int'(rel_idx));
            if (done_valid) compare(32'h2000 | (int'(done_status) << 8) | int'(done_tag));
            if (progress) begin
                prog_seen++;
                prog_free = int'(free_cnt);
            end
        end
    end

    task automatic submit(input int s, input int e, input int n, input bit rel, input int tag);
        @(negedge clk);
        sub_valid = 1'b1; sub_start = IW'(s); sub_end = IW'(e);
        sub_ndesc = IW'(n); sub_release = rel; sub_tag = 4'(tag);
        @(negedge clk);
        sub_valid = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); retire_kick = 1'b1;
        @(negedge clk); retire_kick = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(head_idx == 0 && tail_idx == 0, "R1 reset head/tail", int'(head_idx), 0);
        chk(free_cnt == RD - 1, "R9 reset free", int'(free_cnt), RD - 1);
        eng_running = 1'b1;

        // Two requests; last release of A coincides with its completion (R2, R3).
        submit(0, 3, 3, 1'b1, 1);
        submit(3, 5, 2, 1'b0, 2);
        chk(tail_idx == 5 && generation == 0, "R10 tail after submits", int'(tail_idx), 5);
        chk(free_cnt == 10, "R9 free before pass", int'(free_cnt), 10);
        exp_rel(0, "R2"); exp_rel(1, "R2"); exp_rel(2, "R2");
        exp_done(1, 0, "R3"); exp_done(2, 0, "R3");
        hw_head = 5;
        kick();
        chk(head_idx == 5, "R1 head stops at hw head", int'(head_idx), 5);
        chk(removed_cnt == 5, "R1 removed count", int'(removed_cnt), 5);
        chk(prog_seen == 1 && prog_free == 15, "R9 progress+free", prog_free, 15);

        // Uncovered descriptors 5..7, then wrapping request 8..1 (R4, R10, R1).
        submit(8, 2, 13, 1'b1, 3);
        chk(tail_idx == 2 && generation == 1, "R10 generation wrap", int'(generation), 1);
        for (int i = 8; i < 16; i++) exp_rel(i, "R4");
        exp_rel(0, "R1"); exp_rel(1, "R1");
        exp_done(3, 0, "R3");
        hw_head = 2;
        kick();
        chk(head_idx == 2, "R1 wrapped head", int'(head_idx), 2);
        chk(removed_cnt == 18, "R4 uncovered counted", int'(removed_cnt), 18);
        chk(prog_seen == 2 && prog_free == 15, "R9 second progress", prog_free, 15);

        // Partial retirement of D (2..5).
        submit(2, 6, 4, 1'b1, 4);
        exp_rel(2, "R2"); exp_rel(3, "R2");
        hw_head = 4;
        kick();
        chk(head_idx == 4 && free_cnt == 13, "R9 partial free", int'(free_cnt), 13);

        // Kick while stopped does nothing (R5).
        eng_running = 1'b0;
        hw_head = 6;
        kick();
        chk(head_idx == 4, "R5 stopped kick head", int'(head_idx), 4);
        chk(prog_seen == 3, "R5 no progress when stopped", prog_seen, 3);

        // Stopped submission: D's rest released, D and E aborted in order (R8).
        exp_rel(4, "R8"); exp_rel(5, "R8");
        exp_done(4, 1, "R8"); exp_done(5, 1, "R8");
        submit(7, 8, 1, 1'b1, 5);
        repeat (20) @(negedge clk);
        chk(head_idx == 4 && tail_idx == 6, "R8 pointers kept", int'(tail_idx), 6);
        chk(removed_cnt == 20, "R8 counters kept", int'(removed_cnt), 20);

        // Abort flush with resync (R6, R7).
        eng_running = 1'b1;
        hw_head = 4;
        submit(6, 9, 3, 1'b1, 6);
        submit(9, 10, 1, 1'b0, 7);
        exp_rel(6, "R6"); exp_rel(7, "R6"); exp_rel(8, "R6");
        exp_done(6, 1, "R6"); exp_done(7, 1, "R6");
        @(negedge clk); abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        hw_head = 0;
        repeat (20) @(negedge clk);
        chk(head_idx == 0 && tail_idx == 0, "R7 head/tail zero", int'(tail_idx), 0);
        chk(generation == 0, "R7 generation zero", int'(generation), 0);
        chk(removed_cnt == 26, "R7 removed equals added", int'(removed_cnt), 26);
        chk(free_cnt == 15, "R7 free full", int'(free_cnt), 15);
        chk(exp_q.size() == 0, "R6 all events seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule